// File: doc/BRIEF.md
# E1 Receive System-Side Output Formatter

This block sits between the receive clock/data recovery stage of an E1 line receiver and the system-side pins. It takes the recovered clock, the two recovered rail bits and a code-violation flag. It also takes the two raw slicer rails from before recovery and a loss-of-signal flag. From these it produces a receive clock output and two data pins. Plain configuration inputs select which edge of the output clock launches data, whether the data pins are active high or active low, the output format, and a receive power-down.

There are three formats. In single-rail form the positive pin carries the merged mark data and the negative pin carries one-bit code-violation pulses. In dual-rail form each pin carries its own recovered rail. In slicer-bypass form recovery is skipped: the raw rails go straight to the pins, and the clock output is the XOR of the two rails. Power-down forces every output low.

Top module: `e1_rx_sysfmt`

## Requirements
- R1: While `rst_n` is low, with power-down off, a mode other than 2'b11 and `data_inv` low, both data pins are 0.
- R2: With `edge_fall`=0 (modes 2'b00, 2'b01, 2'b10), the data pins take the formatted value sampled at a rising edge of `rec_clk` at that same rising edge, and hold it through the following falling edge.
- R3: With `edge_fall`=1, the formatted value sampled at a rising edge of `rec_clk` reaches the data pins at the next falling edge, and the pins do not change at the rising edge itself.
- R4: With `data_inv`=1, both data pins are inverted relative to `data_inv`=0. This includes the code-violation pulse on the negative pin in single-rail form.
- R5: Modes 2'b00 and 2'b01 select single-rail form. `rxd_pos_out` carries `rec_pos` OR `rec_neg`, and `rxd_neg_out` carries `rec_cv` for exactly that bit period.
- R6: Mode 2'b10 selects dual-rail form. `rxd_pos_out` carries `rec_pos` and `rxd_neg_out` carries `rec_neg`.
- R7: Mode 2'b11 is slicer bypass. Without any clock, `rxd_pos_out` and `rxd_neg_out` follow `raw_pos` and `raw_neg` (each XOR `data_inv`), and `rxclk_out` equals `raw_pos` XOR `raw_neg`.
- R8: While `rx_pdn`=1, `rxclk_out`, `rxd_pos_out`, `rxd_neg_out` and `los_out` are all 0, whatever the other inputs are.
- R9: While `rx_pdn`=0, `los_out` follows `los_in`.
- R10: While `rx_pdn`=0 and the mode is not 2'b11, `rxclk_out` follows `rec_clk`. The rising edge of `rec_clk` is the rising edge of the output clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rec_clk | input | 1 | Recovered receive clock, nominally 2.048 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_pos | input | 1 | Recovered positive-rail bit |
| rec_neg | input | 1 | Recovered negative-rail bit |
| rec_cv | input | 1 | Code-violation flag for the current bit |
| raw_pos | input | 1 | Raw slicer positive rail, before recovery |
| raw_neg | input | 1 | Raw slicer negative rail, before recovery |
| los_in | input | 1 | Loss-of-signal flag from the receiver |
| edge_fall | input | 1 | Active clock edge: 1 falling, 0 rising |
| data_inv | input | 1 | 1 makes the data pins active low |
| fmt_mode | input | 2 | 00/01 single rail, 10 dual rail, 11 slicer bypass |
| rx_pdn | input | 1 | Receive power-down; forces all outputs low |
| rxclk_out | output | 1 | Receive clock to the system side |
| rxd_pos_out | output | 1 | Data pin (single rail) or positive rail |
| rxd_neg_out | output | 1 | Code-violation pin (single rail) or negative rail |
| los_out | output | 1 | Loss-of-signal to the system side |

## Verification
The assertions check four things on every rising clock edge. In dual-rail, rising-edge operation the positive pin carries the rail bit from the previous edge. In single-rail, rising-edge operation the negative pin carries the violation flag from the previous edge. In bypass the output clock always equals the XOR of the two data pins. During power-down every output stays quiet. Only the bench scenarios show the half-cycle launch in falling-edge operation, the equivalence of the two single-rail codes, the inversion of the violation pulse, and the asynchronous path of the bypass rails. They feed streams of varied rail and violation patterns, and the expected pin values are queued ahead of the output edge.

// File: rtl/e1_rx_sysfmt.sv
module e1_rx_sysfmt (
  input  logic       rec_clk,
  input  logic       rst_n,
  input  logic       rec_pos,
  input  logic       rec_neg,
  input  logic       rec_cv,
  input  logic       raw_pos,
  input  logic       raw_neg,
  input  logic       los_in,
  input  logic       edge_fall,
  input  logic       data_inv,
  input  logic [1:0] fmt_mode,
  input  logic       rx_pdn,
  output logic       rxclk_out,
  output logic       rxd_pos_out,
  output logic       rxd_neg_out,
  output logic       los_out
);
  localparam logic [1:0] MODE_DUAL   = 2'b10;
  localparam logic [1:0] MODE_BYPASS = 2'b11;

  logic       single_rail;
  logic       bypass;
  logic [1:0] fmt_d;
  logic [1:0] rise_q;
  logic [1:0] fall_q;
  logic [1:0] launch;
  logic [1:0] raw_d;
  logic [1:0] pins;

  assign single_rail = ~fmt_mode[1];
  assign bypass      = (fmt_mode == MODE_BYPASS);

  assign fmt_d = (single_rail ? {rec_pos | rec_neg, rec_cv} : {rec_pos, rec_neg})
               ^ {2{data_inv}};

  always_ff @(posedge rec_clk or negedge rst_n)
    if (!rst_n) rise_q <= 2'b00;
    else        rise_q <= fmt_d;

  always_ff @(negedge rec_clk or negedge rst_n)
    if (!rst_n) fall_q <= 2'b00;
    else        fall_q <= rise_q;

  assign launch = edge_fall ? fall_q : rise_q;
  assign raw_d  = {raw_pos, raw_neg} ^ {2{data_inv}};
  assign pins   = rx_pdn ? 2'b00 : (bypass ? raw_d : launch);

  assign rxd_pos_out = pins[1];
  assign rxd_neg_out = pins[0];
  assign rxclk_out   = rx_pdn ? 1'b0 : (bypass ? (raw_pos ^ raw_neg) : rec_clk);
  assign los_out     = rx_pdn ? 1'b0 : los_in;

  assert_dual_pos_R6: assert property (@(posedge rec_clk) disable iff (!rst_n)
    (!rx_pdn && fmt_mode == MODE_DUAL && !edge_fall) |=>
    (rx_pdn || fmt_mode != MODE_DUAL || edge_fall ||
     rxd_pos_out == ($past(rec_pos) ^ $past(data_inv))));

  assert_sr_cv_pulse_R5: assert property (@(posedge rec_clk) disable iff (!rst_n)
    (!rx_pdn && !fmt_mode[1] && !edge_fall) |=>
    (rx_pdn || fmt_mode[1] || edge_fall ||
     rxd_neg_out == ($past(rec_cv) ^ $past(data_inv))));

  assert_bypass_clk_R7: assert property (@(posedge rec_clk) disable iff (!rst_n)
    (!rx_pdn && fmt_mode == MODE_BYPASS) |->
    (rxclk_out == (rxd_pos_out ^ rxd_neg_out)));

  assert_pdn_quiet_R8: assert property (@(posedge rec_clk) disable iff (!rst_n)
    rx_pdn |-> (!rxclk_out && !rxd_pos_out && !rxd_neg_out && !los_out));
endmodule

// File: tb/e1_rx_sysfmt_bench.sv
`timescale 1ns/1ps
module e1_rx_sysfmt_bench;
  localparam int CLK_PERIOD = 488;

  logic       rec_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rec_pos = 0, rec_neg = 0, rec_cv = 0;
  logic       raw_pos = 0, raw_neg = 0, los_in = 0;
  logic       edge_fall = 0, data_inv = 0, rx_pdn = 0;
  logic [1:0] fmt_mode = 2'b10;
  logic       rxclk_out, rxd_pos_out, rxd_neg_out, los_out;

  int total = 0;
  int bad = 0;
  logic       mon_en = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] last_exp = 2'b00;

  e1_rx_sysfmt u_e1_rx_sysfmt (
    .rec_clk(rec_clk), .rst_n(rst_n), .rec_pos(rec_pos), .rec_neg(rec_neg),
    .rec_cv(rec_cv), .raw_pos(raw_pos), .raw_neg(raw_neg), .los_in(los_in),
    .edge_fall(edge_fall), .data_inv(data_inv), .fmt_mode(fmt_mode),
    .rx_pdn(rx_pdn), .rxclk_out(rxclk_out), .rxd_pos_out(rxd_pos_out),
    .rxd_neg_out(rxd_neg_out), .los_out(los_out));

  always #(CLK_PERIOD/2) rec_clk = ~rec_clk;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] expect_pins(input logic [1:0] m, input logic inv,
                                             input logic p, input logic n, input logic cv);
    logic [1:0] v;
    if (m[1] == 1'b0) v = {p | n, cv};
    else              v = {p, n};
    return v ^ {inv, inv};
  endfunction

  always begin
    @(rec_clk);
    #1;
    if (mon_en && exp_q.size() > 0 &&
        ((rec_clk && !edge_fall) || (!rec_clk && edge_fall))) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {2'b00, rxd_pos_out, rxd_neg_out}, {2'b00, e});
    end
  end

  task automatic configure(input logic [1:0] m, input logic inv, input logic fall);
    repeat (2) @(posedge rec_clk);
    mon_en = 1'b0;
    exp_q.delete();
    tag_q.delete();
    fmt_mode = m; data_inv = inv; edge_fall = fall;
    repeat (2) @(posedge rec_clk);
    #1;
    last_exp = {rxd_pos_out, rxd_neg_out};
    mon_en = 1'b1;
  endtask

  task automatic drive(input logic p, input logic n, input logic cv, input string req);
    logic [1:0] e;
    @(negedge rec_clk);
    #(CLK_PERIOD/4);
    rec_pos = p; rec_neg = n; rec_cv = cv;
    e = expect_pins(fmt_mode, data_inv, p, n, cv);
    exp_q.push_back(e);
    tag_q.push_back(req);
    if (edge_fall) begin
      @(posedge rec_clk);
      #1;
      check("R3 hold at rising edge", {2'b00, rxd_pos_out, rxd_neg_out}, {2'b00, last_exp});
    end
    last_exp = e;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    check("R1 reset pins", {2'b00, rxd_pos_out, rxd_neg_out}, 4'b0000);
    @(negedge rec_clk);
    rst_n = 1'b1;

    @(posedge rec_clk); #1;
    check("R10 clock high", {3'b000, rxclk_out}, 4'b0001);
    @(negedge rec_clk); #1;
    check("R10 clock low", {3'b000, rxclk_out}, 4'b0000);

    configure(2'b10, 1'b0, 1'b0);
    drive(1, 0, 0, "R6 R2 dual p");
    drive(0, 1, 0, "R6 R2 dual n");
    drive(0, 0, 0, "R6 R2 dual zero");
    drive(1, 0, 0, "R6 R2 dual p2");
    drive(1, 1, 0, "R6 R2 dual both");
    drive(0, 1, 1, "R6 dual ignores cv");

    configure(2'b00, 1'b0, 1'b0);
    drive(1, 0, 0, "R5 single mark p");
    drive(0, 1, 0, "R5 single mark n");
    drive(0, 0, 1, "R5 single cv pulse");
    drive(0, 0, 0, "R5 single cv ends");
    drive(1, 0, 1, "R5 single mark+cv");

    configure(2'b01, 1'b0, 1'b0);
    drive(0, 1, 1, "R5 mode01 single");
    drive(0, 0, 0, "R5 mode01 space");
    drive(1, 0, 0, "R5 mode01 mark");

    configure(2'b10, 1'b1, 1'b0);
    drive(1, 0, 0, "R4 inv dual p");
    drive(0, 0, 0, "R4 inv dual zero");
    drive(0, 1, 0, "R4 inv dual n");

    configure(2'b00, 1'b1, 1'b0);
    drive(0, 0, 1, "R4 inv cv pulse");
    drive(0, 0, 0, "R4 inv cv idle");

    configure(2'b10, 1'b0, 1'b1);
    drive(1, 0, 0, "R3 fall dual p");
    drive(0, 1, 0, "R3 fall dual n");
    drive(1, 1, 0, "R3 fall both");
    drive(0, 0, 0, "R3 fall zero");

    configure(2'b10, 1'b0, 1'b0);
    mon_en = 1'b0;
    fmt_mode = 2'b11;
    raw_pos = 1; raw_neg = 0; #3;
    check("R7 bypass 10", {1'b0, rxclk_out, rxd_pos_out, rxd_neg_out}, 4'b0110);
    raw_pos = 0; raw_neg = 1; #3;
    check("R7 bypass 01", {1'b0, rxclk_out, rxd_pos_out, rxd_neg_out}, 4'b0101);
    raw_pos = 1; raw_neg = 1; #3;
    check("R7 bypass 11", {1'b0, rxclk_out, rxd_pos_out, rxd_neg_out}, 4'b0011);
    data_inv = 1; raw_pos = 1; raw_neg = 0; #3;
    check("R7 bypass inv", {1'b0, rxclk_out, rxd_pos_out, rxd_neg_out}, 4'b0101);

    los_in = 1; #3;
    check("R9 los follows 1", {3'b000, los_out}, 4'b0001);
    rx_pdn = 1; #3;
    check("R8 pdn bypass", {rxclk_out, rxd_pos_out, rxd_neg_out, los_out}, 4'b0000);
    fmt_mode = 2'b10; data_inv = 1; rec_pos = 1;
    repeat (3) @(posedge rec_clk);
    #1;
    check("R8 pdn dual high", {rxclk_out, rxd_pos_out, rxd_neg_out, los_out}, 4'b0000);
    @(negedge rec_clk); #1;
    check("R8 pdn dual low", {rxclk_out, rxd_pos_out, rxd_neg_out, los_out}, 4'b0000);
    rx_pdn = 0; los_in = 0; #3;
    check("R9 los follows 0", {3'b000, los_out}, 4'b0000);

    repeat (2) @(posedge rec_clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule